// File: doc/BRIEF.md
# GPIO Controller with Strap Capture

This block controls eight general-purpose pins through a small register interface. Software sets three 8-bit fields: direction, weak pull-up enable and output data. For each pin the block drives three pad-control lines: output enable, output level and pull-up enable. When the data field is read, the block returns the live pin levels after a two-stage synchronizer. It does not return the value last written.

A pin that drives low always has its pull-up switched off, whatever its pull-up bit says. This makes the open-drain idiom work on every pin. Software leaves the data bit at 0 and the pull-up bit at 1, then toggles the direction bit. With the direction bit at 0 the pull-up holds the line high. With the direction bit at 1 the pin drives the line low.

Shortly after reset is released, the block samples the shared pins once and holds a 3-bit clock-mode strap and a 1-bit boot strap. These values stay fixed until the next reset.

Top module: `gpio_strap_ctrl`

## Requirements
- R1: While reset is asserted, direction reads 0x00, pull-up reads 0xFF, pad_oe_o is 0x00, pad_pu_o is 0xFF and strap_o is 4'b1111.
- R2: A write with we_i high updates the field chosen by addr_i at the next rising edge. Address 0 selects direction, address 1 selects pull-up and address 2 selects output data. Direction and pull-up read back the value written. With we_i low, no field changes.
- R3: A read at address 2 returns the pin levels delayed by exactly two clock edges.
- R4: For each pin, pad_oe_o equals its direction bit (1 = output) and pad_out_o equals its output data bit.
- R5: When a pin has direction 1 and data 0, its pad_pu_o bit is 0 whatever its pull-up bit says.
- R6: In every other combination, a pin's pad_pu_o bit equals its pull-up bit.
- R7: With data 0 and pull-up 1, direction 0 gives oe=0 and pu=1, and direction 1 gives oe=1, out=0 and pu=0.
- R8: strap_o is loaded on the third rising edge after reset is released. It holds {pin 7, pins 6:4} as sampled through the synchronizer, with bit 3 the boot strap and bits 2:0 the clock-mode strap.
- R9: After capture, strap_o does not change when the pins change, until the next reset.
- R10: Address 3 reads 0x00, and a write to it changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | 2 | Field select: 0 direction, 1 pull-up, 2 data, 3 unused |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from addr_i) |
| pad_in_i | input | 8 | Pin levels from the pads |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin output level |
| pad_pu_o | output | 8 | Per-pin effective weak pull-up enable |
| strap_o | output | 4 | Captured straps: bit 3 boot, bits 2:0 clock mode |

## Verification
The bench builds the block with its default parameters: eight pins, a two-stage synchronizer, the clock-mode strap on pins 6:4 and the boot strap on pin 7. With these values the bench can check the exact two-edge read lag and the exact capture edge of the straps. The defaults also let the bench run two reset cycles with different pin levels, so it can show that the straps change only on a reset and never on later pin activity.

// File: rtl/gpio_strap_pkg.sv
package gpio_strap_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_PULL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } field_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_strap_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] pull_o,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] rdata_o
);
  field_sel_e sel;
  logic [NUM_PINS-1:0] dir_q, pull_q, data_q;

  assign sel = field_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      pull_q <= '1;
      data_q <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_PULL: pull_q <= wdata_i;
        SEL_DATA: data_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  // data reads reflect pins, not the output latch
  always_comb begin
    case (sel)
      SEL_DIR:  rdata_o = dir_q;
      SEL_PULL: rdata_o = pull_q;
      SEL_DATA: rdata_o = pin_sync_i;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign pull_o = pull_q;
  assign data_o = data_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] pull_i,
  input  logic [NUM_PINS-1:0] data_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] pu_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic drive_low;
    assign drive_low = dir_i[p] & ~data_i[p];
    assign oe_o[p]   = dir_i[p];
    assign out_o[p]  = data_i[p];
    // pull-up fights a low driver; kill it
    assign pu_o[p]   = pull_i[p] & ~drive_low;
  end
endmodule

// File: rtl/gpio_strap_latch.sv
module gpio_strap_latch #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned PLL_LSB  = 4,
  parameter int unsigned PLL_W    = 3,
  parameter int unsigned BOOT_PIN = 7,
  parameter int unsigned SETTLE   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  output logic [PLL_W:0]      strap_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [PLL_W:0]   strap_q;
  logic             take;

  assign take = !done_q && (cnt_q == CNT_W'(SETTLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      strap_q <= '1;
    end else if (!done_q) begin
      if (take) begin
        strap_q <= {pin_sync_i[BOOT_PIN], pin_sync_i[PLL_LSB +: PLL_W]};
        done_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/gpio_strap_ctrl.sv
module gpio_strap_ctrl
  import gpio_strap_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PLL_LSB     = 4,
  parameter int unsigned PLL_W       = 3,
  parameter int unsigned BOOT_PIN    = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [PLL_W:0]      strap_o
);
  logic [NUM_PINS-1:0] pin_sync, dir, pull, data;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_sync)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .pin_sync_i(pin_sync), .dir_o(dir), .pull_o(pull), .data_o(data), .rdata_o
  );

  gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pad (
    .dir_i(dir), .pull_i(pull), .data_i(data),
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o)
  );

  gpio_strap_latch #(
    .NUM_PINS(NUM_PINS), .PLL_LSB(PLL_LSB), .PLL_W(PLL_W),
    .BOOT_PIN(BOOT_PIN), .SETTLE(SYNC_STAGES)
  ) u_strap (
    .clk_i, .rst_ni, .pin_sync_i(pin_sync), .strap_o
  );
endmodule

// File: rtl/gpio_strap_ctrl_chk.sv
module gpio_strap_ctrl_chk
  import gpio_strap_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PLL_W       = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_pu_o,
  input logic [PLL_W:0]      strap_o
);
  logic [3:0] up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= '0;
    else if (up_q != 4'hF) up_q <= up_q + 4'd1;
  end

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> pad_oe_o == $past(wdata_i)); // R2

  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2) |=> pad_out_o == $past(wdata_i)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pad_oe_o) && $stable(pad_out_o) && $stable(pad_pu_o))); // R2

  AST_NO_PU_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o & ~pad_out_o) == '0); // R5

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q > 4'(SYNC_STAGES + 1)) |-> $stable(strap_o)); // R9

  AST_UNUSED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> rdata_o == '0); // R10

  if (SYNC_STAGES == 2) begin : g_lag
    AST_READ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_q >= 4'd2 && addr_i == 2'd2) |-> rdata_o == $past(pad_in_i, 2)); // R3
  end
endmodule

bind gpio_strap_ctrl gpio_strap_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES), .PLL_W(PLL_W)
) u_chk (.*);

// File: tb/tb_gpio_strap_ctrl.sv
module tb_gpio_strap_ctrl;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [7:0] dir, pull, data, oe, out, pu;
  } vec_t;

  // expected oe/out/pu per R4..R7
  localparam vec_t VECS [6] = '{
    '{dir:8'hFF, pull:8'hFF, data:8'h00, oe:8'hFF, out:8'h00, pu:8'h00},
    '{dir:8'hFF, pull:8'hFF, data:8'hFF, oe:8'hFF, out:8'hFF, pu:8'hFF},
    '{dir:8'h00, pull:8'hA5, data:8'h00, oe:8'h00, out:8'h00, pu:8'hA5},
    '{dir:8'hF0, pull:8'hFF, data:8'h3C, oe:8'hF0, out:8'h3C, pu:8'h3F},
    '{dir:8'h0F, pull:8'h55, data:8'h0A, oe:8'h0F, out:8'h0A, pu:8'h50},
    '{dir:8'hFF, pull:8'h00, data:8'hC3, oe:8'hFF, out:8'hC3, pu:8'h00}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o, pad_in_i, pad_oe_o, pad_out_o, pad_pu_o;
  logic [3:0] strap_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  gpio_strap_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    pad_in_i = 8'h5A; // pins 7:4 = 0101 -> strap 4'h5
    repeat (3) @(negedge clk_i);
    // R1 reset state
    rd(2'd0, r); check("R1 dir reset", r, 8'h00);
    rd(2'd1, r); check("R1 pull reset", r, 8'hFF);
    check("R1 oe reset", pad_oe_o, 8'h00);
    check("R1 pu reset", pad_pu_o, 8'hFF);
    check("R1 strap reset", {4'h0, strap_o}, 8'h0F);
    rst_ni = 1'b1;
    // R8: edges 1,2 sync, edge 3 loads strap
    @(negedge clk_i); @(negedge clk_i);
    check("R8 strap before capture", {4'h0, strap_o}, 8'h0F);
    @(negedge clk_i);
    check("R8 strap captured", {4'h0, strap_o}, 8'h05);

    // vector table: R2, R4, R5, R6
    foreach (VECS[i]) begin
      wr(2'd0, VECS[i].dir);
      wr(2'd1, VECS[i].pull);
      wr(2'd2, VECS[i].data);
      check("R4 oe", pad_oe_o, VECS[i].oe);
      check("R4 out", pad_out_o, VECS[i].out);
      check("R5 R6 pu", pad_pu_o, VECS[i].pu);
      rd(2'd0, r); check("R2 dir readback", r, VECS[i].dir);
      rd(2'd1, r); check("R2 pull readback", r, VECS[i].pull);
    end

    // R7 open-drain toggling on all pins
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h00);
    check("R7 release oe", pad_oe_o, 8'h00);
    check("R7 release pu", pad_pu_o, 8'hFF);
    wr(2'd0, 8'hFF);
    check("R7 drive oe", pad_oe_o, 8'hFF);
    check("R7 drive out", pad_out_o, 8'h00);
    check("R7 drive pu", pad_pu_o, 8'h00);
    wr(2'd0, 8'h24);
    check("R7 mixed pu", pad_pu_o, 8'hDB);

    // R3 read lag and data read returns pins, not the latch
    wr(2'd2, 8'h0F);
    addr_i = 2'd2;
    @(negedge clk_i);
    pad_in_i = 8'hC6;
    #1 check("R3 lag 0", rdata_o, 8'h5A);
    @(negedge clk_i);
    #1 check("R3 lag 1", rdata_o, 8'h5A);
    @(negedge clk_i);
    #1 check("R3 lag 2", rdata_o, 8'hC6);
    check("R9 strap held", {4'h0, strap_o}, 8'h05);

    // R10 address 3
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h22);
    wr(2'd3, 8'hFF);
    rd(2'd3, r); check("R10 read zero", r, 8'h00);
    rd(2'd0, r); check("R10 dir untouched", r, 8'h11);
    rd(2'd1, r); check("R10 pull untouched", r, 8'h22);
    check("R10 out untouched", pad_out_o, 8'h0F);

    // R2 idle: we low changes nothing
    @(negedge clk_i);
    wdata_i = 8'hAA; addr_i = 2'd0;
    @(negedge clk_i);
    check("R2 no write oe", pad_oe_o, 8'h11);

    // R9 second reset with new straps
    pad_in_i = 8'h80; // pin7=1, pins 6:4=000 -> 4'h8
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 strap in reset", {4'h0, strap_o}, 8'h0F);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R8 strap second", {4'h0, strap_o}, 8'h08);
    pad_in_i = 8'h7F;
    repeat (5) @(negedge clk_i);
    check("R9 strap frozen", {4'h0, strap_o}, 8'h08);

    finish_run();
  end
endmodule